// File: doc/BRIEF.md
# Host Register Front End with Interrupt Latch and Byte FIFO

This block sits between a host byte bus and the sequencing logic of a SCSI-style bus controller. The host reads and writes single bytes at a small set of addresses. Behind those addresses are a data FIFO, a read-to-clear interrupt cause register, a status register, an occupancy (flags) register, a configuration byte and a command port. An internal sequencer sets interrupt cause bits and the terminal-count flag through request inputs. The block keeps one registered, active-high interrupt line that is high exactly while a cause is pending.

The host sees a read result on `rdata_o` in the same cycle it asserts `rd_en_i`. The side effects of a read, such as a FIFO pop or clearing the causes, take effect at the next rising clock edge. The command port accepts three operations in the low nibble of the written byte: flush the FIFO, reset the block, and request a bus reset. A bus reset request reports itself as an interrupt cause unless the host has masked that report in the configuration byte.

Address map (`addr_i`): 0 = FIFO data, 1 = command (write only, reads 0x00), 2 = status (read only), 3 = interrupt causes, 4 = flags, 5 = configuration. Addresses 6 and 7 are unused.

Top module: `regfront_top`

## Requirements
- R1: After hard reset the interrupt line is low and status, interrupt causes and flags all read 0x00. The configuration byte reads 0x07.
- R2: Each bit set on `seq_set_i` in a cycle is ORed into the interrupt cause register. If any cause bit is set, the interrupt line and status bit 7 are high from the next cycle on. With no cause pending and no new cause, the line stays low.
- R3: A read of address 3 returns the pending causes. At the next edge it clears every cause bit, clears the terminal-count bit (status bit 4) and lowers the interrupt line. A cause or terminal-count request arriving in the same cycle as the read survives the clear.
- R4: A read of address 4 returns the FIFO occupancy (0 to 16) in bits 4:0, with bits 7:5 zero.
- R5: A write to address 0 appends the byte to the 16-entry FIFO. A read of address 0 returns the oldest byte and removes it, so bytes leave in arrival order.
- R6: A write to address 0 while the FIFO holds 16 bytes is dropped. The stored bytes and the occupancy are unchanged, and the overrun bit (status bit 6) is set.
- R7: A read of address 0 while the FIFO is empty returns 0x00 and leaves the occupancy at 0.
- R8: Writing opcode 0x1 to address 1 empties the FIFO and clears the overrun bit.
- R9: Writing opcode 0x2 to address 1 returns every register, the FIFO and the interrupt line to the values of R1.
- R10: Writing opcode 0x3 to address 1 sets cause bit 7 and raises the interrupt line, unless configuration bit 6 is set. In that case it has no effect on causes or the line.
- R11: A pulse on `seq_tc_i` sets status bit 4 without raising the interrupt line.
- R12: In a cycle with both strobes high only the write takes place. Writes to addresses 2, 6 and 7 change nothing, and reads of addresses 1, 6 and 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low hard reset |
| addr_i | input | 3 | Host register address |
| wr_en_i | input | 1 | Host write strobe |
| wdata_i | input | 8 | Host write byte |
| rd_en_i | input | 1 | Host read strobe; side effects apply at the next edge |
| rdata_o | output | 8 | Read byte for the current address |
| seq_set_i | input | 8 | Interrupt cause set requests from the sequencer |
| seq_tc_i | input | 1 | Terminal-count set request from the sequencer |
| irq_o | output | 1 | Registered active-high interrupt line |

## Verification
The bound assertions check every cycle that the interrupt line tracks exactly whether any cause is pending. They also check that it never rises without a request and falls after a cause read. On each edge they confirm that the occupancy stays at the limit on an overrun push and at zero on an empty pop, and that a soft reset or a masked bus reset leaves the line low. Several things are shown only by the bench scenarios: byte order through a full wrap of the FIFO, the exact cause values read back, a same-cycle cause surviving a read clear, flush clearing the overrun bit, and the write-wins rule for simultaneous strobes.

// File: rtl/regfront_pkg.sv
`timescale 1ns/1ps
package regfront_pkg;

    localparam int ADDR_W = 3;
    localparam int BYTE_W = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_FIFO  = 3'd0,
        A_CMD   = 3'd1,
        A_STAT  = 3'd2,
        A_INTR  = 3'd3,
        A_FLAGS = 3'd4,
        A_CFG1  = 3'd5
    } reg_addr_e;

    localparam logic [3:0] OP_NOP    = 4'h0;
    localparam logic [3:0] OP_FLUSH  = 4'h1;
    localparam logic [3:0] OP_SWRST  = 4'h2;
    localparam logic [3:0] OP_BUSRST = 4'h3;

    localparam int STAT_IRQ_BIT   = 7;
    localparam int STAT_OVR_BIT   = 6;
    localparam int STAT_TC_BIT    = 4;
    localparam int CFG1_NORPT_BIT = 6;
    localparam int CAUSE_BUSRST   = 7;

    localparam logic [BYTE_W-1:0] CFG1_RST = 8'h07;

    typedef struct packed {
        logic [BYTE_W-1:0] intr;
        logic              irq;
        logic              tc;
        logic              ovr;
        logic [BYTE_W-1:0] cfg1;
    } ctl_state_t;

    localparam ctl_state_t CTL_RESET = '{
        intr: '0, irq: 1'b0, tc: 1'b0, ovr: 1'b0, cfg1: CFG1_RST
    };

endpackage

// File: rtl/regfront_fifo.sv
`timescale 1ns/1ps
module regfront_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 8,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    input  logic             pop_i,
    input  logic             flush_i,
    input  logic [WIDTH-1:0] wdata_i,
    output logic [WIDTH-1:0] head_o,
    output logic [CNT_W-1:0] count_o,
    output logic             full_o
);

    typedef struct packed {
        logic [PTR_W-1:0] wr;
        logic [PTR_W-1:0] rd;
        logic [CNT_W-1:0] cnt;
    } ptr_state_t;

    ptr_state_t q, d;
    logic [WIDTH-1:0] mem [DEPTH];
    logic do_push_d, do_pop_d, empty;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full_o  = (q.cnt == CNT_W'(DEPTH));
    assign empty   = (q.cnt == '0);
    assign count_o = q.cnt;
    // An empty FIFO presents zero instead of stale storage.
    assign head_o  = empty ? '0 : mem[q.rd];

    always_comb begin
        d         = q;
        do_push_d = push_i && !full_o && !flush_i;
        do_pop_d  = pop_i && !empty && !flush_i;
        if (flush_i) begin
            d = '0;
        end else begin
            if (do_push_d) d.wr = bump(q.wr);
            if (do_pop_d)  d.rd = bump(q.rd);
            d.cnt = q.cnt + CNT_W'(do_push_d) - CNT_W'(do_pop_d);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    always_ff @(posedge clk_i) begin
        if (do_push_d) mem[q.wr] <= wdata_i;
    end

endmodule

// File: rtl/regfront_rdmux.sv
`timescale 1ns/1ps
module regfront_rdmux
    import regfront_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  ctl_state_t        st_i,
    input  logic [BYTE_W-1:0] head_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic [BYTE_W-1:0] rdata_o
);

    logic [BYTE_W-1:0] stat_byte;

    always_comb begin
        stat_byte               = '0;
        stat_byte[STAT_IRQ_BIT] = st_i.irq;
        stat_byte[STAT_OVR_BIT] = st_i.ovr;
        stat_byte[STAT_TC_BIT]  = st_i.tc;
    end

    always_comb begin
        case (addr_i)
            A_FIFO:  rdata_o = head_i;
            A_STAT:  rdata_o = stat_byte;
            A_INTR:  rdata_o = st_i.intr;
            A_FLAGS: rdata_o = BYTE_W'(count_i);
            A_CFG1:  rdata_o = st_i.cfg1;
            default: rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/regfront_top.sv
`timescale 1ns/1ps
module regfront_top
    import regfront_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_en_i,
    input  logic [BYTE_W-1:0] wdata_i,
    input  logic              rd_en_i,
    output logic [BYTE_W-1:0] rdata_o,
    input  logic [BYTE_W-1:0] seq_set_i,
    input  logic              seq_tc_i,
    output logic              irq_o
);

    ctl_state_t st_q, st_d;

    logic              wr_act, rd_act;
    logic              fifo_push, fifo_pop, fifo_flush, fifo_full;
    logic              cmd_wr;
    logic [3:0]        opcode;
    logic [BYTE_W-1:0] fifo_head;
    logic [CNT_W-1:0]  fifo_cnt;
    logic [BYTE_W-1:0] new_cause;

    // A write strobe masks a simultaneous read.
    assign wr_act     = wr_en_i;
    assign rd_act     = rd_en_i && !wr_en_i;
    assign cmd_wr     = wr_act && (addr_i == A_CMD);
    assign opcode     = wdata_i[3:0];
    assign fifo_push  = wr_act && (addr_i == A_FIFO);
    assign fifo_pop   = rd_act && (addr_i == A_FIFO);
    assign fifo_flush = cmd_wr && ((opcode == OP_FLUSH) || (opcode == OP_SWRST));

    regfront_fifo #(
        .DEPTH (DEPTH),
        .WIDTH (BYTE_W)
    ) i_fifo (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .push_i  (fifo_push),
        .pop_i   (fifo_pop),
        .flush_i (fifo_flush),
        .wdata_i (wdata_i),
        .head_o  (fifo_head),
        .count_o (fifo_cnt),
        .full_o  (fifo_full)
    );

    always_comb begin
        new_cause = seq_set_i;
        if (cmd_wr && (opcode == OP_BUSRST) && !st_q.cfg1[CFG1_NORPT_BIT]) begin
            new_cause[CAUSE_BUSRST] = 1'b1;
        end
    end

    always_comb begin
        st_d = st_q;
        // Read-to-clear first, so that same-cycle requests survive.
        if (rd_act && (addr_i == A_INTR)) begin
            st_d.intr = '0;
            st_d.tc   = 1'b0;
            st_d.irq  = 1'b0;
        end
        st_d.intr = st_d.intr | new_cause;
        if (new_cause != '0) st_d.irq = 1'b1;
        if (seq_tc_i)        st_d.tc  = 1'b1;
        if (fifo_push && fifo_full) st_d.ovr = 1'b1;
        if (fifo_flush)             st_d.ovr = 1'b0;
        if (wr_act && (addr_i == A_CFG1)) st_d.cfg1 = wdata_i;
        if (cmd_wr && (opcode == OP_SWRST)) st_d = CTL_RESET;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= CTL_RESET;
        else         st_q <= st_d;
    end

    regfront_rdmux #(
        .CNT_W (CNT_W)
    ) i_rdmux (
        .addr_i  (addr_i),
        .st_i    (st_q),
        .head_i  (fifo_head),
        .count_i (fifo_cnt),
        .rdata_o (rdata_o)
    );

    assign irq_o = st_q.irq;

endmodule

// File: rtl/regfront_checker.sv
`timescale 1ns/1ps
module regfront_checker
    import regfront_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_en_i,
    input logic [BYTE_W-1:0] wdata_i,
    input logic              rd_en_i,
    input logic [BYTE_W-1:0] rdata_i,
    input logic [BYTE_W-1:0] seq_set_i,
    input logic              irq_i,
    input logic [CNT_W-1:0]  fifo_cnt_i,
    input logic [BYTE_W-1:0] intr_q_i,
    input logic              ovr_q_i,
    input logic [BYTE_W-1:0] cfg1_q_i
);

    logic host_rd, cmd_wr;
    assign host_rd = rd_en_i && !wr_en_i;
    assign cmd_wr  = wr_en_i && (addr_i == A_CMD);

    assert_irq_tracks_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_i == (intr_q_i != '0));

    assert_no_spurious_irq_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!irq_i && (seq_set_i == '0) && !cmd_wr) |=> !irq_i);

    assert_cause_read_clears_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_rd && (addr_i == A_INTR) && (seq_set_i == '0)) |=> !irq_i);

    assert_flags_match_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_rd && (addr_i == A_FLAGS)) |-> (int'(rdata_i) <= DEPTH) && (rdata_i == BYTE_W'(fifo_cnt_i)));

    assert_full_push_dropped_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en_i && (addr_i == A_FIFO) && (fifo_cnt_i == CNT_W'(DEPTH))) |=> (fifo_cnt_i == CNT_W'(DEPTH)) && ovr_q_i);

    assert_empty_pop_zero_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_rd && (addr_i == A_FIFO) && (fifo_cnt_i == '0)) |-> (rdata_i == '0));

    assert_empty_pop_stays_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (host_rd && (addr_i == A_FIFO) && (fifo_cnt_i == '0)) |=> (fifo_cnt_i == '0));

    assert_soft_reset_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_wr && (wdata_i[3:0] == OP_SWRST)) |=> (cfg1_q_i == CFG1_RST) && !irq_i && (fifo_cnt_i == '0));

    assert_busrst_masked_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_wr && (wdata_i[3:0] == OP_BUSRST) && cfg1_q_i[CFG1_NORPT_BIT] && (seq_set_i == '0) && !irq_i) |=> !irq_i);

endmodule

bind regfront_top regfront_checker #(.DEPTH(DEPTH)) i_regfront_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .addr_i     (addr_i),
    .wr_en_i    (wr_en_i),
    .wdata_i    (wdata_i),
    .rd_en_i    (rd_en_i),
    .rdata_i    (rdata_o),
    .seq_set_i  (seq_set_i),
    .irq_i      (irq_o),
    .fifo_cnt_i (fifo_cnt),
    .intr_q_i   (st_q.intr),
    .ovr_q_i    (st_q.ovr),
    .cfg1_q_i   (st_q.cfg1)
);

// File: tb/test_regfront_top.sv
`timescale 1ns/1ps
module test_regfront_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic [7:0] wdata = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rdata;
    logic [7:0] seq_set = '0;
    logic       seq_tc = 1'b0;
    logic       irq;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [2:0] addr;
        logic [7:0] exp;
        string      tag;
    } rd_exp_t;
    rd_exp_t sb_q[$];

    always #2.5 clk = ~clk;

    regfront_top #(.DEPTH(16)) i_regfront_top (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .addr_i    (addr),
        .wr_en_i   (wr_en),
        .wdata_i   (wdata),
        .rd_en_i   (rd_en),
        .rdata_o   (rdata),
        .seq_set_i (seq_set),
        .seq_tc_i  (seq_tc),
        .irq_o     (irq)
    );

    // Monitor: compare each read result against the scoreboard head.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rd_en && !wr_en) begin
                if (sb_q.size() == 0) begin
                    n_err++;
                    $display("FAIL R12 unexpected read addr %0d actual %h expected none", addr, rdata);
                end else begin
                    rd_exp_t e;
                    e = sb_q.pop_front();
                    n_chk++;
                    if (rdata !== e.exp)
                        begin
                            n_err++;
                            $display("FAIL %s addr %0d actual %h expected %h", e.tag, e.addr, rdata, e.exp);
                        end
                end
            end
        end
    end

    task automatic host_rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
        rd_exp_t e;
        e.addr = a; e.exp = exp; e.tag = tag;
        sb_q.push_back(e);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic seq_pulse(input logic [7:0] c, input logic tc);
        seq_set = c; seq_tc = tc;
        @(negedge clk);
        seq_set = '0; seq_tc = 1'b0;
    endtask

    task automatic chk_irq(input logic exp, input string tag);
        n_chk++;
        if (irq !== exp) begin
            n_err++;
            $display("FAIL %s irq actual %0b expected %0b", tag, irq, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5);
        n_err++;
        $display("FAIL watchdog expired actual running expected finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset values
        chk_irq(1'b0, "R1");
        host_rd(3'd5, 8'h07, "R1 cfg1");
        host_rd(3'd2, 8'h00, "R1 status");
        host_rd(3'd3, 8'h00, "R1 intr");
        host_rd(3'd4, 8'h00, "R1 flags");

        // R5 ordering, R4 occupancy, R7 empty pop
        host_wr(3'd0, 8'hA1);
        host_wr(3'd0, 8'hB2);
        host_wr(3'd0, 8'hC3);
        host_rd(3'd4, 8'h03, "R4 flags three");
        host_rd(3'd0, 8'hA1, "R5 pop first");
        host_rd(3'd0, 8'hB2, "R5 pop second");
        host_rd(3'd4, 8'h01, "R4 flags one");
        host_rd(3'd0, 8'hC3, "R5 pop third");
        host_rd(3'd0, 8'h00, "R7 empty pop");
        host_rd(3'd4, 8'h00, "R7 flags after empty pop");

        // R6 overrun on full FIFO
        for (int k = 0; k < 16; k++) host_wr(3'd0, 8'(k * 17 + 3));
        host_rd(3'd4, 8'h10, "R4 flags full");
        host_wr(3'd0, 8'hEE);
        host_rd(3'd4, 8'h10, "R6 flags after overrun");
        host_rd(3'd2, 8'h40, "R6 overrun bit");
        for (int k = 0; k < 16; k++) host_rd(3'd0, 8'(k * 17 + 3), "R6 data intact");
        host_rd(3'd4, 8'h00, "R5 drained");

        // R8 flush
        host_wr(3'd0, 8'h11);
        host_wr(3'd0, 8'h22);
        host_rd(3'd2, 8'h40, "R6 overrun held");
        host_wr(3'd1, 8'h01);
        host_rd(3'd4, 8'h00, "R8 flags after flush");
        host_rd(3'd2, 8'h00, "R8 overrun cleared");

        // R2 cause accumulation, R3 read-to-clear
        seq_pulse(8'h04, 1'b0);
        chk_irq(1'b1, "R2 raise");
        host_rd(3'd2, 8'h80, "R2 status irq bit");
        seq_pulse(8'h10, 1'b0);
        chk_irq(1'b1, "R2 stays high");
        host_rd(3'd3, 8'h14, "R3 cause value");
        chk_irq(1'b0, "R3 lowered");
        host_rd(3'd2, 8'h00, "R3 status after clear");
        host_rd(3'd3, 8'h00, "R3 causes cleared");

        // R11 terminal count, cleared by cause read (R3)
        seq_pulse(8'h00, 1'b1);
        chk_irq(1'b0, "R11 no irq from tc");
        host_rd(3'd2, 8'h10, "R11 tc bit");
        host_rd(3'd3, 8'h00, "R3 read with tc set");
        host_rd(3'd2, 8'h00, "R3 tc cleared");

        // R3 same-cycle cause survives the clear
        seq_pulse(8'h02, 1'b0);
        seq_set = 8'h08;
        host_rd(3'd3, 8'h02, "R3 read during new cause");
        seq_set = 8'h00;
        chk_irq(1'b1, "R3 new cause keeps irq");
        host_rd(3'd3, 8'h08, "R3 surviving cause");
        chk_irq(1'b0, "R3 lowered again");

        // R10 bus reset reporting and masking
        host_wr(3'd1, 8'h03);
        chk_irq(1'b1, "R10 bus reset raises");
        host_rd(3'd3, 8'h80, "R10 cause bit7");
        host_wr(3'd5, 8'h47);
        host_rd(3'd5, 8'h47, "R10 cfg1 written");
        host_wr(3'd1, 8'h03);
        chk_irq(1'b0, "R10 masked no irq");
        host_rd(3'd3, 8'h00, "R10 masked no cause");

        // R12 write wins, unused addresses
        addr = 3'd0; wdata = 8'h5A; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        host_rd(3'd4, 8'h01, "R12 write only on both strobes");
        host_wr(3'd2, 8'hFF);
        host_wr(3'd6, 8'hFF);
        host_wr(3'd7, 8'hFF);
        host_rd(3'd2, 8'h00, "R12 status write ignored");
        host_rd(3'd6, 8'h00, "R12 unused read");
        host_rd(3'd1, 8'h00, "R12 command read");
        host_rd(3'd0, 8'h5A, "R12 pushed byte");
        chk_irq(1'b0, "R12 no irq");

        // R9 soft reset
        host_wr(3'd0, 8'h77);
        seq_pulse(8'h01, 1'b1);
        chk_irq(1'b1, "R9 irq before reset");
        host_wr(3'd1, 8'h02);
        chk_irq(1'b0, "R9 irq after reset");
        host_rd(3'd4, 8'h00, "R9 flags");
        host_rd(3'd5, 8'h07, "R9 cfg1");
        host_rd(3'd2, 8'h00, "R9 status");
        host_rd(3'd3, 8'h00, "R9 intr");

        repeat (2) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_err++;
            $display("FAIL R12 scoreboard left actual %0d expected 0", sb_q.size());
        end
        finish_run();
    end

endmodule